// File: doc/BRIEF.md
# ECC Memory Bus Termination Controller

This block sits on the slave side of a RAM protected by an error-correcting code and decides how each asynchronous processor bus cycle ends. It watches a cycle strobe, a data-ready indication and the result of the ECC check. From these it drives three termination lines to the processor: data acknowledge, bus error and halt. The ECC logic and the RAM array sit outside the block.

A two-bit policy input selects one of four ways to end a cycle. The block samples it once, when a cycle begins. In the two late policies the acknowledge waits for the check result. A bad word then either requests an automatic retry (bus error and halt together) or raises a bus-error exception (bus error alone). In the two early policies the acknowledge goes out as soon as data is ready. A bad word found on the following clock adds bus error, or bus error with halt, one clock after the acknowledge. On every retry, halt is held for a parameterized scrub window and a one-clock write strobe asks the memory to store the corrected word. Bus error and halt are then released on the same clock.

Top module: `ecc_term_ctrl`

## Requirements
- R1: After reset, ack_o, berr_o, halt_o and fix_we_o are all low.
- R2: The clock after cyc_i is sampled low, ack_o, berr_o and halt_o are all low. No termination is driven while no cycle is active, including the first clock after a cycle starts.
- R3: In a late policy (mode_i 0 or 1), no output rises until chk_vld_i is sampled high, and rdy_i is ignored. If chk_err_i is low, only ack_o rises, on the clock that samples chk_vld_i.
- R4: Under policy 0 (late, retry), a check error raises berr_o and halt_o together on that clock, with ack_o low.
- R5: Under policy 1 (late, exception), a check error raises berr_o alone, with ack_o and halt_o low.
- R6: In an early policy (mode_i 2 or 3), ack_o rises on the clock that samples rdy_i high. The ECC inputs are ignored before that clock.
- R7: Under policy 2 (early, exception), chk_vld_i and chk_err_i sampled high on the clock after the acknowledge raise berr_o, with ack_o still high and halt_o low.
- R8: Under policy 3 (early, retry), the same error condition raises berr_o and halt_o together on the clock after the acknowledge.
- R9: On a retry, halt_o stays high for exactly SCRUB_CYC clocks. berr_o and halt_o (and ack_o) then fall on the same clock.
- R10: fix_we_o is high for exactly the first clock of each halt window and at no other time.
- R11: mode_i is sampled only on the clock that starts a cycle. A change to it during the cycle does not alter that cycle's termination.
- R12: In an early policy with a clean check result, ack_o stays high alone until the strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_i | input | 1 | Bus cycle strobe, high while a cycle is active |
| rdy_i | input | 1 | Read data available from RAM |
| chk_vld_i | input | 1 | ECC check result valid |
| chk_err_i | input | 1 | ECC check found an error (meaningful with chk_vld_i) |
| mode_i | input | 2 | Termination policy: 0 late/retry, 1 late/exception, 2 early/exception, 3 early/retry |
| ack_o | output | 1 | Data acknowledge to the processor |
| berr_o | output | 1 | Bus error to the processor |
| halt_o | output | 1 | Halt to the processor |
| fix_we_o | output | 1 | One-clock request to write the corrected word back |

## Verification
The case hardest to reach from the ports is an error on an early-acknowledge cycle. It needs data-ready on one clock, then a bad check result on exactly the next. It also needs the mode to be changed after the cycle has started, so that a policy sampled at the wrong time would show. The stimulus walks every policy through this sequence with random wait lengths. It raises the ECC inputs (or rdy_i in late policies) during the waiting phase to show they are ignored. It also rewrites mode_i right after each cycle starts, both in directed cases and in a seeded random loop.

// File: rtl/ecc_term_pkg.sv
`timescale 1ns/1ps
package ecc_term_pkg;

   typedef enum logic [1:0] {
      POL_LATE_RETRY  = 2'd0,
      POL_LATE_EXC    = 2'd1,
      POL_EARLY_EXC   = 2'd2,
      POL_EARLY_RETRY = 2'd3
   } policy_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_VERIFY,
      ST_DONE,
      ST_HOLD,
      ST_REL
   } term_state_e;

   typedef struct packed {
      logic early;
      logic retry;
   } policy_t;

   function automatic policy_t decode_policy(input logic [1:0] m);
      policy_t p;
      p.early = (m == POL_EARLY_EXC) || (m == POL_EARLY_RETRY);
      p.retry = (m == POL_LATE_RETRY) || (m == POL_EARLY_RETRY);
      return p;
   endfunction

endpackage

// File: rtl/ecc_term_policy.sv
`timescale 1ns/1ps
module ecc_term_policy
   import ecc_term_pkg::*;
#(
   parameter bit ALLOW_EARLY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [1:0] mode_i,
   output policy_t    pol_o
);

   policy_t pol_d;
   policy_t pol_q;

   generate
      if (ALLOW_EARLY) begin : g_full
         assign pol_d = decode_policy(mode_i);
      end else begin : g_late_only
         policy_t raw;
         assign raw   = decode_policy(mode_i);
         assign pol_d = '{early: 1'b0, retry: raw.retry};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pol_q <= '0;
      else if (start_i) pol_q <= pol_d;
   end

   assign pol_o = pol_q;

   a_r11_policy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(pol_q));

endmodule

// File: rtl/ecc_term_hold_timer.sv
`timescale 1ns/1ps
module ecc_term_hold_timer #(
   parameter int SCRUB_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic done_o
);

   localparam int CNT_W = (SCRUB_CYC > 1) ? $clog2(SCRUB_CYC) : 1;
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SCRUB_CYC - 1);

   generate
      if (SCRUB_CYC < 1) begin : g_bad_scrub
         $error("SCRUB_CYC must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load_i)        cnt_q <= LOAD_VAL;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

   a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LOAD_VAL);

endmodule

// File: rtl/ecc_term_fsm.sv
`timescale 1ns/1ps
module ecc_term_fsm
   import ecc_term_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cyc_i,
   input  logic    rdy_i,
   input  logic    chk_vld_i,
   input  logic    chk_err_i,
   input  policy_t pol_i,
   input  logic    tmr_done_i,
   output logic    start_o,
   output logic    tmr_load_o,
   output logic    ack_o,
   output logic    berr_o,
   output logic    halt_o,
   output logic    fix_we_o
);

   term_state_e st_q, st_d;
   logic ack_q, berr_q, halt_q, fix_q;
   logic ack_d, berr_d, halt_d, fix_d;

   always_comb begin
      st_d       = st_q;
      ack_d      = ack_q;
      berr_d     = berr_q;
      halt_d     = halt_q;
      fix_d      = 1'b0;
      start_o    = 1'b0;
      tmr_load_o = 1'b0;
      if (!cyc_i) begin
         st_d   = ST_IDLE;
         ack_d  = 1'b0;
         berr_d = 1'b0;
         halt_d = 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               start_o = 1'b1;
               st_d    = ST_WAIT;
            end
            ST_WAIT: begin
               if (!pol_i.early) begin
                  if (chk_vld_i) begin
                     if (!chk_err_i) begin
                        ack_d = 1'b1;
                        st_d  = ST_DONE;
                     end else if (pol_i.retry) begin
                        berr_d     = 1'b1;
                        halt_d     = 1'b1;
                        fix_d      = 1'b1;
                        tmr_load_o = 1'b1;
                        st_d       = ST_HOLD;
                     end else begin
                        berr_d = 1'b1;
                        st_d   = ST_DONE;
                     end
                  end
               end else if (rdy_i) begin
                  ack_d = 1'b1;
                  st_d  = ST_VERIFY;
               end
            end
            ST_VERIFY: begin
               st_d = ST_DONE;
               if (chk_vld_i && chk_err_i) begin
                  berr_d = 1'b1;
                  if (pol_i.retry) begin
                     halt_d     = 1'b1;
                     fix_d      = 1'b1;
                     tmr_load_o = 1'b1;
                     st_d       = ST_HOLD;
                  end
               end
            end
            ST_HOLD: begin
               if (tmr_done_i) begin
                  ack_d  = 1'b0;
                  berr_d = 1'b0;
                  halt_d = 1'b0;
                  st_d   = ST_REL;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ack_q  <= 1'b0;
         berr_q <= 1'b0;
         halt_q <= 1'b0;
         fix_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         ack_q  <= ack_d;
         berr_q <= berr_d;
         halt_q <= halt_d;
         fix_q  <= fix_d;
      end
   end

   assign ack_o    = ack_q;
   assign berr_o   = berr_q;
   assign halt_o   = halt_q;
   assign fix_we_o = fix_q;

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_i |=> (!ack_o && !berr_o && !halt_o));
   a_r4_halt_needs_berr: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |-> berr_o);
   a_r5_exc_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (berr_o && !pol_i.retry) |-> !halt_o);
   a_r3_late_ack_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && !pol_i.early) |-> !berr_o);
   a_r9_release_together: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halt_o) |-> $fell(berr_o));
   a_r10_fix_single: assert property (@(posedge clk) disable iff (!rst_n)
      fix_we_o |=> !fix_we_o);
   a_r10_fix_on_halt_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_o) |-> fix_we_o);

endmodule

// File: rtl/ecc_term_ctrl.sv
`timescale 1ns/1ps
module ecc_term_ctrl
   import ecc_term_pkg::*;
#(
   parameter int SCRUB_CYC   = 2,
   parameter bit ALLOW_EARLY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cyc_i,
   input  logic       rdy_i,
   input  logic       chk_vld_i,
   input  logic       chk_err_i,
   input  logic [1:0] mode_i,
   output logic       ack_o,
   output logic       berr_o,
   output logic       halt_o,
   output logic       fix_we_o
);

   policy_t pol;
   logic    start;
   logic    tmr_load;
   logic    tmr_done;

   ecc_term_policy #(.ALLOW_EARLY(ALLOW_EARLY)) u_policy (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .mode_i  (mode_i),
      .pol_o   (pol)
   );

   ecc_term_hold_timer #(.SCRUB_CYC(SCRUB_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .done_o (tmr_done)
   );

   ecc_term_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cyc_i      (cyc_i),
      .rdy_i      (rdy_i),
      .chk_vld_i  (chk_vld_i),
      .chk_err_i  (chk_err_i),
      .pol_i      (pol),
      .tmr_done_i (tmr_done),
      .start_o    (start),
      .tmr_load_o (tmr_load),
      .ack_o      (ack_o),
      .berr_o     (berr_o),
      .halt_o     (halt_o),
      .fix_we_o   (fix_we_o)
   );

endmodule

// File: tb/sim_ecc_term_ctrl.sv
`timescale 1ns/1ps
module sim_ecc_term_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int SCRUB      = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_i = 1'b0;
   logic       rdy_i = 1'b0;
   logic       chk_vld_i = 1'b0;
   logic       chk_err_i = 1'b0;
   logic [1:0] mode_i = 2'd0;
   logic       ack_o, berr_o, halt_o, fix_we_o;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ecc_term_ctrl #(.SCRUB_CYC(SCRUB)) u0 (
      .clk(clk), .rst_n(rst_n), .cyc_i(cyc_i), .rdy_i(rdy_i),
      .chk_vld_i(chk_vld_i), .chk_err_i(chk_err_i), .mode_i(mode_i),
      .ack_o(ack_o), .berr_o(berr_o), .halt_o(halt_o), .fix_we_o(fix_we_o)
   );

   function automatic bit is_early(input logic [1:0] m);
      return m[1];
   endfunction

   function automatic bit is_retry(input logic [1:0] m);
      return (m == 2'd0) || (m == 2'd3);
   endfunction

   task automatic chk(input string tag, input bit a, input bit b, input bit h, input bit f);
      checks++;
      if ({ack_o, berr_o, halt_o, fix_we_o} !== {a, b, h, f}) begin
         errors++;
         $display("FAIL %s: ack/berr/halt/fix got %b%b%b%b expected %b%b%b%b",
                  tag, ack_o, berr_o, halt_o, fix_we_o, a, b, h, f);
      end
   endtask

   // One bus cycle under policy m; mode_i is rewritten to mnew right after the start.
   task automatic run_cycle(input logic [1:0] m, input bit err, input int dly,
                            input logic [1:0] mnew);
      bit    e   = is_early(m);
      bit    r   = is_retry(m);
      string ovr = (mnew != m) ? "R11" : "";
      string tg;
      @(negedge clk);
      mode_i = m; cyc_i = 1'b1; rdy_i = 1'b0; chk_vld_i = 1'b0; chk_err_i = 1'b0;
      @(negedge clk);
      mode_i = mnew;
      chk("R2", 0, 0, 0, 0);
      // waiting phase: the inputs the policy must ignore are raised
      for (int i = 0; i < dly; i++) begin
         if (e) begin chk_vld_i = 1'b1; chk_err_i = 1'b1; end
         else   rdy_i = 1'b1;
         @(negedge clk);
         chk(e ? "R6" : "R3", 0, 0, 0, 0);
      end
      rdy_i = 1'b0; chk_vld_i = 1'b0; chk_err_i = 1'b0;
      if (!e) begin
         chk_vld_i = 1'b1; chk_err_i = err;
         @(negedge clk);
         chk_vld_i = 1'b0; chk_err_i = 1'b0;
         if (!err)   begin tg = (ovr != "") ? ovr : "R3"; chk(tg, 1, 0, 0, 0); end
         else if (r) begin tg = (ovr != "") ? ovr : "R4"; chk(tg, 0, 1, 1, 1); end
         else        begin tg = (ovr != "") ? ovr : "R5"; chk(tg, 0, 1, 0, 0); end
      end else begin
         rdy_i = 1'b1;
         @(negedge clk);
         rdy_i = 1'b0;
         chk("R6", 1, 0, 0, 0);
         chk_vld_i = 1'b1; chk_err_i = err;
         @(negedge clk);
         chk_vld_i = 1'b0; chk_err_i = 1'b0;
         if (!err)   begin tg = (ovr != "") ? ovr : "R12"; chk(tg, 1, 0, 0, 0); end
         else if (r) begin tg = (ovr != "") ? ovr : "R8";  chk(tg, 1, 1, 1, 1); end
         else        begin tg = (ovr != "") ? ovr : "R7";  chk(tg, 1, 1, 0, 0); end
      end
      if (err && r) begin
         for (int i = 1; i < SCRUB; i++) begin
            @(negedge clk);
            chk("R9", e, 1, 1, 0);
         end
         @(negedge clk);
         chk("R9", 0, 0, 0, 0);
         @(negedge clk);
         chk("R10", 0, 0, 0, 0);
      end else begin
         @(negedge clk);
         if (!err)  chk(e ? "R12" : "R3", 1, 0, 0, 0);
         else if (e) chk("R7", 1, 1, 0, 0);
         else        chk("R5", 0, 1, 0, 0);
      end
      cyc_i = 1'b0;
      @(negedge clk);
      chk("R2", 0, 0, 0, 0);
   endtask

   initial begin
      void'($urandom(32'h5EED_0C7A));
      repeat (3) @(negedge clk);
      chk("R1", 0, 0, 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", 0, 0, 0, 0);
      // no cycle: ECC and ready inputs do nothing
      rdy_i = 1'b1; chk_vld_i = 1'b1; chk_err_i = 1'b1;
      repeat (3) @(negedge clk);
      chk("R2", 0, 0, 0, 0);
      rdy_i = 1'b0; chk_vld_i = 1'b0; chk_err_i = 1'b0;
      // directed: every policy, clean and bad, shortest and longer wait
      for (int m = 0; m < 4; m++) begin
         run_cycle(2'(m), 1'b0, 0, 2'(m));
         run_cycle(2'(m), 1'b1, 0, 2'(m));
         run_cycle(2'(m), 1'b1, 2, 2'(m));
      end
      // directed mode swap mid-cycle
      run_cycle(2'd1, 1'b1, 1, 2'd0);
      run_cycle(2'd2, 1'b1, 1, 2'd3);
      run_cycle(2'd0, 1'b0, 0, 2'd2);
      // seeded random
      for (int n = 0; n < 60; n++) begin
         run_cycle(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                   int'($urandom_range(0, 4)), 2'($urandom_range(0, 3)));
      end
      if (!ended) begin
         ended = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, got hung expected done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule